// File: doc/BRIEF.md
# Tamper-Cleared Backup Register File

This block is a small register file of 16-bit words that lives in a battery-backed domain. A processor reads and writes it through a simple select/write/address port. The words survive every ordinary system reset and standby wake-up; only a dedicated active-low domain reset sets them to zero. The bus side can reach the words only while a peripheral interface enable is high, and writes also need a separate domain-access enable.

A tamper input is passed through a flop synchroniser into a three-state controller. The states are `TS_ARMED`, `TS_WIPE` and `TS_LATCHED`. The transitions are:
- `TS_ARMED` to `TS_WIPE` when the synchronised tamper level is high.
- `TS_WIPE` to `TS_LATCHED` if the level is still high.
- `TS_WIPE` to `TS_ARMED` if the level has already fallen.
- `TS_LATCHED` to `TS_ARMED` once the level falls.

During the single `TS_WIPE` cycle every word is cleared and a sticky tamper flag is set. One word, selected by a parameter, holds a calibration value and is driven on a dedicated output for an attached timekeeping counter.

Address map:
- Addresses below `NUM_WORDS` are storage words.
- Address `NUM_WORDS` is a control word. Bit 0 reads back the tamper flag, and writing a one to bit 0 clears the flag.
- Anything above `NUM_WORDS` is out of range.

Top module: `bkreg_file`

## Requirements
- R1: Asserting the system reset `sys_rst_n` leaves every stored word and `cal_out` unchanged.
- R2: Asserting `dom_rst_n` clears every stored word, `cal_out` and the tamper flag to zero.
- R3: A write issued while `dom_wr_en` is low changes no stored word.
- R4: While `bus_clk_en` is low, a read returns zero and a write is dropped.
- R5: A read issued in one cycle presents the addressed word on `rdata` after the next rising clock edge. `rdata` is zero in cycles that follow no read.
- R6: A rising tamper level clears all words to zero and sets the flag. The sequence is two synchroniser edges, one edge to enter `TS_WIPE`, and the clearing edge, so the words read zero after the fourth rising edge following the change.
- R7: A write that lands on the same edge as the clear is discarded. A write one edge earlier is stored and then wiped.
- R8: Tamper acts on the edge only. While the level stays high the file accepts writes again, and a fresh clear needs the level to fall and rise again.
- R9: The tamper flag is visible on `tamper_flag` and in bit 0 of the control word at address `NUM_WORDS`. Writing that word with bit 0 set clears the flag; bit 0 clear leaves it set.
- R10: `cal_out` always equals stored word `CAL_IDX` (default 0).
- R11: A read above address `NUM_WORDS` returns zero and raises `rd_err` for exactly the one cycle in which its data is presented. A write above that address changes nothing.
- R12: `sys_rst_n` clears only the read path: `rdata` and `rd_err` are zero while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset, read path only |
| dom_rst_n | input | 1 | Active-low backup-domain reset |
| bus_clk_en | input | 1 | Peripheral interface enable |
| dom_wr_en | input | 1 | Backup-domain write permission |
| tamper_in | input | 1 | Asynchronous tamper level |
| sel | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_err | output | 1 | Out-of-range read pulse |
| cal_out | output | DATA_W | Calibration word |
| tamper_flag | output | 1 | Sticky tamper-event flag |

## Verification
Most of the array is visible only through reads, so a corrupted word shows one cycle after a read of its address. The exception is word `CAL_IDX`, which shows on `cal_out` on the same edge it changes. A controller stuck outside `TS_ARMED` shows as a clear that never happens, or as writes being lost, within four edges of a tamper transition. A flag or decode fault shows at once on `tamper_flag`, on `rd_err`, or on the control-word read. The sweep writes and reads every address of the 4-bit space, both in range and out of range, and compares each result with a pattern computed from the address.

// File: rtl/bkreg_pkg.sv
package bkreg_pkg;

    typedef enum logic [1:0] {
        TS_ARMED   = 2'b00,
        TS_WIPE    = 2'b01,
        TS_LATCHED = 2'b10
    } tamp_state_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_WORD = 2'b01,
        ACC_CTRL = 2'b10,
        ACC_BAD  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/bkreg_tamper_sync.sv
module bkreg_tamper_sync
    import bkreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        dom_rst_n,
    input  logic        tamper_in,
    output tamp_state_e state_o,
    output logic        wipe_o
);

    logic        level_sync;
    tamp_state_e state_q;
    tamp_state_e state_d;

    generate
        if (SYNC_STAGES < 2) begin : g_single
            logic sync_q;
            always_ff @(posedge clk or negedge dom_rst_n) begin
                if (!dom_rst_n) sync_q <= 1'b0;
                else            sync_q <= tamper_in;
            end
            assign level_sync = sync_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge dom_rst_n) begin
                if (!dom_rst_n) sync_q <= '0;
                else            sync_q <= {sync_q[SYNC_STAGES-2:0], tamper_in};
            end
            assign level_sync = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge dom_rst_n) begin
        if (!dom_rst_n) state_q <= TS_ARMED;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_ARMED:   if (level_sync)  state_d = TS_WIPE;
            TS_WIPE:    state_d = level_sync ? TS_LATCHED : TS_ARMED;
            TS_LATCHED: if (!level_sync) state_d = TS_ARMED;
            default:    state_d = TS_ARMED;
        endcase
    end

    always_comb begin
        wipe_o  = (state_q == TS_WIPE);
        state_o = state_q;
    end

endmodule

// File: rtl/bkreg_array.sv
module bkreg_array #(
    parameter int NUM_WORDS = 10,
    parameter int DATA_W    = 16,
    parameter int CAL_IDX   = 0,
    parameter int IDX_W     = 4
) (
    input  logic                             clk,
    input  logic                             dom_rst_n,
    input  logic                             wipe,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 waddr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             flag_clr,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    output logic                             flag,
    output logic [DATA_W-1:0]                cal
);

    generate
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
            always_ff @(posedge clk or negedge dom_rst_n) begin
                if (!dom_rst_n)                         words[i] <= '0;
                else if (wipe)                          words[i] <= '0;
                else if (we && (waddr == IDX_W'(i)))    words[i] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge dom_rst_n) begin
        if (!dom_rst_n)    flag <= 1'b0;
        else if (wipe)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assign cal = words[CAL_IDX];

endmodule

// File: rtl/bkreg_bus.sv
module bkreg_bus
    import bkreg_pkg::*;
#(
    parameter int NUM_WORDS = 10,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = 4
) (
    input  logic                             clk,
    input  logic                             sys_rst_n,
    input  logic                             bus_clk_en,
    input  logic                             dom_wr_en,
    input  logic                             sel,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             wbit0,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    input  logic                             flag,
    output logic                             word_we,
    output logic [IDX_W-1:0]                 word_idx,
    output logic                             flag_clr,
    output logic [DATA_W-1:0]                rdata,
    output logic                             rd_err
);

    acc_kind_e         kind;
    logic [DATA_W-1:0] rd_val;
    logic              rd_bad;

    always_comb begin
        kind = ACC_NONE;
        if (sel && bus_clk_en) begin
            if (int'(addr) < NUM_WORDS)       kind = ACC_WORD;
            else if (int'(addr) == NUM_WORDS) kind = ACC_CTRL;
            else                              kind = ACC_BAD;
        end
    end

    always_comb begin
        word_idx = addr[IDX_W-1:0];
        word_we  = (kind == ACC_WORD) && wr && dom_wr_en;
        flag_clr = (kind == ACC_CTRL) && wr && dom_wr_en && wbit0;
    end

    always_comb begin
        rd_val = '0;
        rd_bad = 1'b0;
        if (!wr) begin
            unique case (kind)
                ACC_WORD: rd_val = words[word_idx];
                ACC_CTRL: rd_val = DATA_W'(flag);
                ACC_BAD:  rd_bad = 1'b1;
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            rdata  <= '0;
            rd_err <= 1'b0;
        end else begin
            rdata  <= rd_val;
            rd_err <= rd_bad;
        end
    end

endmodule

// File: rtl/bkreg_file.sv
module bkreg_file
    import bkreg_pkg::*;
#(
    parameter int NUM_WORDS   = 10,
    parameter int DATA_W      = 16,
    parameter int CAL_IDX     = 0,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              dom_rst_n,
    input  logic              bus_clk_en,
    input  logic              dom_wr_en,
    input  logic              tamper_in,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_err,
    output logic [DATA_W-1:0] cal_out,
    output logic              tamper_flag
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    tamp_state_e                     tamp_state;
    logic                            tamp_wipe;
    logic                            word_we;
    logic [IDX_W-1:0]                word_idx;
    logic                            flag_clr;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    bkreg_tamper_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tamper (
        .clk      (clk),
        .dom_rst_n(dom_rst_n),
        .tamper_in(tamper_in),
        .state_o  (tamp_state),
        .wipe_o   (tamp_wipe)
    );

    bkreg_bus #(
        .NUM_WORDS(NUM_WORDS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_bus (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .bus_clk_en(bus_clk_en),
        .dom_wr_en (dom_wr_en),
        .sel       (sel),
        .wr        (wr),
        .addr      (addr),
        .wbit0     (wdata[0]),
        .words     (words),
        .flag      (tamper_flag),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .flag_clr  (flag_clr),
        .rdata     (rdata),
        .rd_err    (rd_err)
    );

    bkreg_array #(
        .NUM_WORDS(NUM_WORDS),
        .DATA_W   (DATA_W),
        .CAL_IDX  (CAL_IDX),
        .IDX_W    (IDX_W)
    ) u_array (
        .clk      (clk),
        .dom_rst_n(dom_rst_n),
        .wipe     (tamp_wipe),
        .we       (word_we),
        .waddr    (word_idx),
        .wdata    (wdata),
        .flag_clr (flag_clr),
        .words    (words),
        .flag     (tamper_flag),
        .cal      (cal_out)
    );

endmodule

// File: rtl/bkreg_file_chk.sv
module bkreg_file_chk #(
    parameter int NUM_WORDS = 10,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4
) (
    input logic              clk,
    input logic              sys_rst_n,
    input logic              dom_rst_n,
    input logic              bus_clk_en,
    input logic              dom_wr_en,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_err,
    input logic [DATA_W-1:0] cal_out,
    input logic              tamper_flag,
    input logic              wipe
);

    logic any_rst_n;
    logic past_ok;

    assign any_rst_n = sys_rst_n & dom_rst_n;

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) past_ok <= 1'b0;
        else            past_ok <= 1'b1;
    end

    // R11: an error pulse carries zero data
    a_r11_err_zero: assert property (@(posedge clk) disable iff (!any_rst_n)
        rd_err |-> (rdata == '0));

    // R11: an error pulse has an out-of-range read behind it
    a_r11_err_cause: assert property (@(posedge clk) disable iff (!any_rst_n)
        (past_ok && rd_err) |-> $past(sel && !wr && bus_clk_en && (int'(addr) > NUM_WORDS)));

    // R4: a gated read returns zero
    a_r4_gated_read: assert property (@(posedge clk) disable iff (!any_rst_n)
        (past_ok && $past(sel && !wr && !bus_clk_en)) |-> (rdata == '0));

    // R3: no write permission and no wipe keeps the calibration word
    a_r3_no_write: assert property (@(posedge clk) disable iff (!any_rst_n)
        (past_ok && !$past(dom_wr_en) && !$past(wipe)) |-> $stable(cal_out));

    // R6: the wipe cycle leaves zero words and a set flag
    a_r6_wipe_clears: assert property (@(posedge clk) disable iff (!any_rst_n)
        wipe |=> ((cal_out == '0) && tamper_flag));

    // R8: a single wipe cycle per tamper edge
    a_r8_single_wipe: assert property (@(posedge clk) disable iff (!any_rst_n)
        wipe |=> !wipe);

    // R9: the flag moves only on a wipe or a permitted control write
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!any_rst_n)
        (past_ok && !$past(wipe)
         && !$past(sel && wr && bus_clk_en && dom_wr_en && (int'(addr) == NUM_WORDS)))
        |-> $stable(tamper_flag));

endmodule

bind bkreg_file bkreg_file_chk #(
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .sys_rst_n  (sys_rst_n),
    .dom_rst_n  (dom_rst_n),
    .bus_clk_en (bus_clk_en),
    .dom_wr_en  (dom_wr_en),
    .sel        (sel),
    .wr         (wr),
    .addr       (addr),
    .rdata      (rdata),
    .rd_err     (rd_err),
    .cal_out    (cal_out),
    .tamper_flag(tamper_flag),
    .wipe       (tamp_wipe)
);

// File: tb/bkreg_file_bench.sv
module bkreg_file_bench;

    localparam int NW = 10;
    localparam int AW = 4;
    localparam int AMAX = 16;

    logic          clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          dom_rst_n = 1'b0;
    logic          bus_clk_en = 1'b0;
    logic          dom_wr_en = 1'b0;
    logic          tamper_in = 1'b0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          rd_err;
    logic [15:0]   cal_out;
    logic          tamper_flag;

    int tests = 0;
    int fails = 0;
    logic [15:0] model [NW];
    logic        model_flag = 1'b0;

    always #5 clk = ~clk;

    bkreg_file #(.NUM_WORDS(NW)) u_bkreg_file (
        .clk(clk), .sys_rst_n(sys_rst_n), .dom_rst_n(dom_rst_n),
        .bus_clk_en(bus_clk_en), .dom_wr_en(dom_wr_en), .tamper_in(tamper_in),
        .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rd_err(rd_err), .cal_out(cal_out), .tamper_flag(tamper_flag)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'hA5C3 ^ 16'(a * 16'h1111);
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(input int a, input logic [15:0] d);
        sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic do_rd(input int a, output logic [15:0] d, output logic e);
        sel = 1'b1; wr = 1'b0; addr = AW'(a);
        @(negedge clk);
        d = rdata; e = rd_err;
        sel = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [15:0] d;
        logic        e;
        for (int a = 0; a < NW; a++) begin
            do_rd(a, d, e);
            check(req, d, model[a]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] d;
        logic        e;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R12 reset rdata", rdata, 16'h0);
        check("R12 reset rd_err", 16'(rd_err), 16'h0);
        check("R2 reset cal_out", cal_out, 16'h0);
        check("R2 reset flag", 16'(tamper_flag), 16'h0);
        sys_rst_n = 1'b1; dom_rst_n = 1'b1;
        bus_clk_en = 1'b1; dom_wr_en = 1'b1;
        @(negedge clk);

        // R5 R11 sweep over the whole address space
        for (int a = 0; a < AMAX; a++) begin
            do_wr(a, pat(a));
            if (a < NW) model[a] = pat(a);
            else if (a == NW && pat(a)[0]) model_flag = 1'b0;
        end
        for (int a = 0; a < AMAX; a++) begin
            do_rd(a, d, e);
            check("R5 sweep data", d, (a < NW) ? model[a] : (a == NW) ? 16'(model_flag) : 16'h0);
            check("R11 sweep err", 16'(e), 16'(a > NW));
        end
        @(negedge clk);
        check("R11 err one cycle", 16'(rd_err), 16'h0);
        check("R5 idle rdata", rdata, 16'h0);
        check("R10 cal_out", cal_out, model[0]);

        // R3 no write permission
        dom_wr_en = 1'b0;
        for (int a = 0; a < NW; a++) do_wr(a, ~pat(a));
        dom_wr_en = 1'b1;
        check_all("R3 blocked write");
        check("R10 cal after blocked", cal_out, model[0]);

        // R4 gated interface
        bus_clk_en = 1'b0;
        do_wr(3, 16'h1234);
        do_rd(3, d, e);
        check("R4 gated read", d, 16'h0);
        bus_clk_en = 1'b1;
        do_rd(3, d, e);
        check("R4 gated write dropped", d, model[3]);

        // R1 R12 system reset
        sys_rst_n = 1'b0;
        @(negedge clk);
        check("R12 sysrst rdata", rdata, 16'h0);
        sys_rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 survive sysrst");
        check("R1 cal survives", cal_out, model[0]);

        // R6 R7 tamper clear, write on the clear edge lost
        tamper_in = 1'b1;
        @(negedge clk); @(negedge clk);
        do_wr(5, 16'hFFFF);
        do_wr(6, 16'hBEEF);
        for (int i = 0; i < NW; i++) model[i] = '0;
        model_flag = 1'b1;
        check("R6 cal cleared", cal_out, 16'h0);
        check("R6 flag set", 16'(tamper_flag), 16'h1);
        do_rd(6, d, e);
        check("R7 write on clear edge", d, 16'h0);
        do_rd(5, d, e);
        check("R7 write before clear", d, 16'h0);
        check_all("R6 all cleared");
        do_rd(NW, d, e);
        check("R9 control read", d, 16'h1);

        // R8 level held high, writes accepted again
        do_wr(2, 16'h5555); model[2] = 16'h5555;
        do_wr(0, 16'h0C0C); model[0] = 16'h0C0C;
        repeat (4) @(negedge clk);
        check_all("R8 writes while held");
        check("R10 cal follows", cal_out, 16'h0C0C);

        // R9 flag clear behaviour
        do_wr(NW, 16'hFFFE);
        check("R9 zero bit keeps flag", 16'(tamper_flag), 16'h1);
        do_wr(NW, 16'h0001);
        check("R9 clear flag", 16'(tamper_flag), 16'h0);
        do_rd(NW, d, e);
        check("R9 control read clear", d, 16'h0);

        // R11 out-of-range write has no effect
        do_wr(NW + 3, 16'h7777);
        check_all("R11 bad write ignored");

        // R8 fresh edge after falling
        tamper_in = 1'b0;
        repeat (5) @(negedge clk);
        check_all("R8 fall no clear");
        tamper_in = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < NW; i++) model[i] = '0;
        check_all("R8 second edge clears");
        check("R8 flag again", 16'(tamper_flag), 16'h1);
        tamper_in = 1'b0;
        repeat (4) @(negedge clk);

        // R2 domain reset
        do_wr(4, 16'h4444);
        dom_rst_n = 1'b0;
        @(negedge clk);
        dom_rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 domain reset");
        check("R2 flag reset", 16'(tamper_flag), 16'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule